// File: doc/BRIEF.md
# Flash Self-Programming Command Register

This block is the register the CPU uses to start operations on its own program flash. Software writes an operation-enable bit in bit 0, together with at most one command bit. That write arms a short window. If the core raises a program-store strobe or a program-load strobe of the matching kind inside the window, the block turns the strobe into one of these operations:

- a temporary-buffer fill
- a buffer clear
- a page erase
- a page write
- a read of the fuse or lock byte

If no matching strobe arrives, the armed command lapses and nothing is issued.

Page erase and page write are long operations. Their length comes from a cycle-count parameter that stands in for the calibrated oscillator's timing. While one runs, the block keeps `fl_busy` high, refuses new commands, and shows the running command in the register. A reset that arrives during such an operation does not cut it short. The flash array, the page buffer storage and the fuse/lock storage lie outside the block.

Top module: `selfprog_ctl`

## Requirements
- R1: After reset, `reg_rdata` is 0x00, `fl_busy`, `fl_start` and `cfg_valid` are 0.
- R2: Bits 7..5 of `reg_rdata` always read zero; writing ones to them has no effect on the value read back or on the command armed.
- R3: A write with bit 0 set and at most one of bits 4..1 set arms that command, and the register reads back exactly those bits (bit 1 erase, bit 2 page write, bit 3 fuse/lock read, bit 4 buffer clear, none = buffer fill); a write with bit 0 clear disarms and reads back 0x00.
- R4: A store command (fill, erase, write, clear) is claimed by `st_stb` sampled on any of the four rising edges after the write edge; a load strobe does not claim it; with no claim by the fourth edge the register returns to 0x00 and nothing is issued.
- R5: A claimed erase or page write gives a one-cycle `fl_start` pulse in the cycle after the claiming edge, with `fl_op` = 1 for erase and 2 for write, and `fl_page` = `zptr[15:5]` sampled at the claiming edge.
- R6: After an erase or write starts, `fl_busy` is high for exactly PROG_CYCLES cycles; during that time the register reads bit 0 set plus the running command bit (0x03 erase, 0x05 write), and it reads 0x00 once `fl_busy` falls.
- R7: Register writes made while `fl_busy` is high are ignored: the read value is unchanged and no command stays armed afterwards.
- R8: A fuse/lock read command (0x09) is claimed by `ld_stb` on any of the three rising edges after the write edge; the next cycle `cfg_valid` pulses with `cfg_data` = `lock_bits` when `zptr[0]` is 1 and `fuse_bits` when it is 0; a store strobe does not claim it, and a load strobe on the fourth edge gives no `cfg_valid`.
- R9: A claimed buffer fill gives `fl_start` with `fl_op` = 0 and `fl_offs` = `zptr[4:1]`; a claimed buffer clear gives `fl_op` = 3; neither raises `fl_busy`.
- R10: A write with bit 0 set and two or more of bits 4..1 set arms nothing: it reads back 0x00 and a following strobe issues nothing.
- R11: Reset asserted while `fl_busy` is high does not shorten the operation: `fl_busy` stays high for the full PROG_CYCLES counted from the start, and the register keeps showing the running command.
- R12: A claiming strobe on the last window edge is honoured, and a register write on the same edge as a claiming strobe is dropped, so the claimed command is the one that runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| st_stb | input | 1 | Program-store instruction strobe from the core |
| ld_stb | input | 1 | Program-load instruction strobe from the core |
| zptr | input | 16 | Address pointer from the core |
| fuse_bits | input | 8 | Fuse byte from configuration storage |
| lock_bits | input | 8 | Lock byte from configuration storage |
| cfg_valid | output | 1 | One-cycle pulse: cfg_data holds the fuse/lock byte |
| cfg_data | output | 8 | Fuse or lock byte returned for a load strobe |
| fl_start | output | 1 | One-cycle flash command pulse |
| fl_op | output | 2 | Flash command: 0 fill, 1 erase, 2 write, 3 clear |
| fl_page | output | 11 | Page number for erase and write |
| fl_offs | output | 4 | Word offset inside the page for fill |
| fl_busy | output | 1 | Erase or write in progress |

## Verification
Three things can land on the same rising edge: the window running out, a claiming strobe, and a new register write. The window-end case is provoked by a strobe three idle cycles after the write for a store and two for a load. The bench judges it by the `fl_start` or `cfg_valid` pulse, and by its absence one cycle later. The strobe/write collision is provoked by raising `reg_wr` with a different command in the claiming cycle. It is judged by `fl_op` and by the register reading back the claimed command, not the newer one, for the whole busy time.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;

  // Flash command codes presented on fl_op
  typedef enum logic [1:0] {
    OP_FILL  = 2'd0,
    OP_ERASE = 2'd1,
    OP_WRITE = 2'd2,
    OP_CLEAR = 2'd3
  } fl_op_e;

  // Register bit positions (decoded by software, so fixed)
  localparam int BIT_EN   = 0;
  localparam int CMD_LSB  = 1;
  localparam int CMD_MSB  = 4;
  localparam int REG_W    = 8;

  // Command field, register bits 4..1
  typedef struct packed {
    logic clr;   // bit 4
    logic cfg;   // bit 3
    logic wr;    // bit 2
    logic er;    // bit 1
  } cmd_t;

endpackage

// File: rtl/sp_window.sv
module sp_window
  import selfprog_pkg::*;
#(
  parameter int ST_WIN = 4,
  parameter int LD_WIN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic req_en,
  input  cmd_t req_cmd,
  input  logic busy,
  input  logic st_stb,
  input  logic ld_stb,
  output logic armed,
  output cmd_t cmd,
  output logic st_claim,
  output logic ld_claim
);

  localparam int WIN_MAX = (ST_WIN > LD_WIN) ? ST_WIN : LD_WIN;
  localparam int CW      = $clog2(WIN_MAX + 1);

  logic          armed_q;
  cmd_t          cmd_q;
  logic [CW-1:0] win_q;
  logic          legal;
  logic          claim;

  always_comb begin
    legal    = ($countones(req_cmd) <= 1);
    st_claim = armed_q && st_stb && !cmd_q.cfg;
    ld_claim = armed_q && ld_stb &&  cmd_q.cfg;
    claim    = st_claim || ld_claim;
  end

  // Priority: claim, then register write, then window countdown
  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      cmd_q   <= '0;
      win_q   <= '0;
    end else if (claim) begin
      armed_q <= 1'b0;
      cmd_q   <= '0;
      win_q   <= '0;
    end else if (wr_en && !busy) begin
      if (req_en && legal) begin
        armed_q <= 1'b1;
        cmd_q   <= req_cmd;
        win_q   <= req_cmd.cfg ? CW'(LD_WIN) : CW'(ST_WIN);
      end else begin
        armed_q <= 1'b0;
        cmd_q   <= '0;
        win_q   <= '0;
      end
    end else if (armed_q) begin
      if (win_q == CW'(1)) begin
        armed_q <= 1'b0;
        cmd_q   <= '0;
        win_q   <= '0;
      end else begin
        win_q   <= win_q - CW'(1);
      end
    end
  end

  assign armed = armed_q;
  assign cmd   = cmd_q;

  AST_WIN_RANGE: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (win_q != '0 && win_q <= CW'(WIN_MAX))); // R4
  AST_ONE_CMD: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_q)); // R10
  AST_CLAIM_DISARMS: assert property (@(posedge clk) disable iff (rst)
    claim |=> !armed_q); // R12
  AST_IDLE_DISARMED: assert property (@(posedge clk) disable iff (rst)
    !armed_q |-> (cmd_q == '0)); // R4

endmodule

// File: rtl/sp_prog_timer.sv
module sp_prog_timer #(
  parameter int PROG_CYCLES = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic start_write,
  output logic busy,
  output logic run_write
);

  localparam int TW = $clog2(PROG_CYCLES + 1);

  logic [TW-1:0] tmr_q;
  logic          run_wr_q;

  // Reset does not stop a running operation; a new start needs rst low.
  always_ff @(posedge clk) begin
    if (start && !rst) begin
      tmr_q <= TW'(PROG_CYCLES);
    end else if (tmr_q != '0) begin
      tmr_q <= tmr_q - TW'(1);
    end else begin
      tmr_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (start && !rst) begin
      run_wr_q <= start_write;
    end else if (tmr_q != '0) begin
      run_wr_q <= run_wr_q;
    end else begin
      run_wr_q <= 1'b0;
    end
  end

  assign busy      = (tmr_q != '0);
  assign run_write = run_wr_q;

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    start |=> busy); // R6
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tmr_q > TW'(1)) |=> busy); // R6
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy); // R7

endmodule

// File: rtl/sp_cfg_read.sv
module sp_cfg_read #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          claim,
  input  logic          sel_lock,
  input  logic [DW-1:0] fuse_bits,
  input  logic [DW-1:0] lock_bits,
  output logic          valid,
  output logic [DW-1:0] data
);

  logic          valid_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= claim;
      if (claim) data_q <= sel_lock ? lock_bits : fuse_bits;
    end
  end

  assign valid = valid_q;
  assign data  = data_q;

  AST_CFG_FROM_CLAIM: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> $past(claim)); // R8
  AST_CFG_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q); // R8

endmodule

// File: rtl/selfprog_ctl.sv
module selfprog_ctl
  import selfprog_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PAGE_BYTES  = 32,
  parameter int PROG_CYCLES = 40,
  parameter int ST_WIN      = 4,
  parameter int LD_WIN      = 3,
  localparam int PG_LSB     = $clog2(PAGE_BYTES),
  localparam int PAGE_W     = ADDR_W - PG_LSB,
  localparam int OFFS_W     = PG_LSB - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              st_stb,
  input  logic              ld_stb,
  input  logic [ADDR_W-1:0] zptr,
  input  logic [7:0]        fuse_bits,
  input  logic [7:0]        lock_bits,
  output logic              cfg_valid,
  output logic [7:0]        cfg_data,
  output logic              fl_start,
  output logic [1:0]        fl_op,
  output logic [PAGE_W-1:0] fl_page,
  output logic [OFFS_W-1:0] fl_offs,
  output logic              fl_busy
);

  logic   armed;
  cmd_t   cmd;
  logic   st_claim;
  logic   ld_claim;
  logic   busy;
  logic   run_write;
  logic   long_start;
  fl_op_e op_next;
  logic   wdata_unused;

  assign wdata_unused = ^reg_wdata[REG_W-1:CMD_MSB+1];

  sp_window #(.ST_WIN(ST_WIN), .LD_WIN(LD_WIN)) u_window (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr),
    .req_en   (reg_wdata[BIT_EN]),
    .req_cmd  (cmd_t'(reg_wdata[CMD_MSB:CMD_LSB])),
    .busy     (busy),
    .st_stb   (st_stb),
    .ld_stb   (ld_stb),
    .armed    (armed),
    .cmd      (cmd),
    .st_claim (st_claim),
    .ld_claim (ld_claim)
  );

  always_comb begin
    if (cmd.er)       op_next = OP_ERASE;
    else if (cmd.wr)  op_next = OP_WRITE;
    else if (cmd.clr) op_next = OP_CLEAR;
    else              op_next = OP_FILL;
    long_start = st_claim && (cmd.er || cmd.wr);
  end

  sp_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .start       (long_start),
    .start_write (cmd.wr),
    .busy        (busy),
    .run_write   (run_write)
  );

  sp_cfg_read #(.DW(8)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .claim     (ld_claim),
    .sel_lock  (zptr[0]),
    .fuse_bits (fuse_bits),
    .lock_bits (lock_bits),
    .valid     (cfg_valid),
    .data      (cfg_data)
  );

  // Registered flash command port
  always_ff @(posedge clk) begin
    if (rst) begin
      fl_start <= 1'b0;
      fl_op    <= OP_FILL;
      fl_page  <= '0;
      fl_offs  <= '0;
    end else begin
      fl_start <= st_claim;
      if (st_claim) begin
        fl_op   <= op_next;
        fl_page <= zptr[ADDR_W-1:PG_LSB];
        fl_offs <= zptr[PG_LSB-1:1];
      end
    end
  end

  // Read view: the running command while busy, the armed one otherwise
  always_comb begin
    reg_rdata = '0;
    if (busy) begin
      reg_rdata[BIT_EN] = 1'b1;
      reg_rdata[CMD_MSB:CMD_LSB] = run_write ? 4'b0010 : 4'b0001;
    end else begin
      reg_rdata[BIT_EN] = armed;
      reg_rdata[CMD_MSB:CMD_LSB] = cmd;
    end
  end

  assign fl_busy = busy;

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    fl_start |=> !fl_start); // R5
  AST_ARM_IDLE: assert property (@(posedge clk) disable iff (rst)
    armed |-> !fl_busy); // R7
  AST_CLAIM_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(st_claim && ld_claim)); // R8

endmodule

// File: tb/test_selfprog_ctl.sv
module test_selfprog_ctl;

  localparam int CLK_PERIOD = 10;
  localparam int PROG       = 40;
  localparam logic [7:0] FUSE = 8'h3C;
  localparam logic [7:0] LOCK = 8'hA5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        st_stb = 1'b0;
  logic        ld_stb = 1'b0;
  logic [15:0] zptr = '0;
  logic        cfg_valid;
  logic [7:0]  cfg_data;
  logic        fl_start;
  logic [1:0]  fl_op;
  logic [10:0] fl_page;
  logic [3:0]  fl_offs;
  logic        fl_busy;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  selfprog_ctl #(.PROG_CYCLES(PROG)) i_selfprog_ctl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .st_stb(st_stb), .ld_stb(ld_stb), .zptr(zptr),
    .fuse_bits(FUSE), .lock_bits(LOCK), .cfg_valid(cfg_valid),
    .cfg_data(cfg_data), .fl_start(fl_start), .fl_op(fl_op),
    .fl_page(fl_page), .fl_offs(fl_offs), .fl_busy(fl_busy)
  );

  // kind: 0 nothing issued, 1 flash command, 2 fuse/lock read
  typedef struct packed {
    logic [7:0]  wd;
    logic [2:0]  gap;
    logic        use_ld;
    logic [15:0] z;
    logic [1:0]  kind;
    logic [1:0]  op;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{8'h05, 3'd0, 1'b0, 16'h1234, 2'd1, 2'd2}, // R5 write, first edge
    '{8'h03, 3'd3, 1'b0, 16'hABCD, 2'd1, 2'd1}, // R5 R12 erase, last edge
    '{8'h03, 3'd4, 1'b0, 16'h4444, 2'd0, 2'd0}, // R4 too late
    '{8'h09, 3'd2, 1'b1, 16'h0001, 2'd2, 2'd0}, // R8 lock, last edge
    '{8'h09, 3'd0, 1'b1, 16'h0000, 2'd2, 2'd0}, // R8 fuse
    '{8'h09, 3'd3, 1'b1, 16'h0001, 2'd0, 2'd0}, // R8 too late
    '{8'h11, 3'd1, 1'b0, 16'h7F00, 2'd1, 2'd3}, // R9 clear
    '{8'h01, 3'd2, 1'b0, 16'h003E, 2'd1, 2'd0}, // R9 fill
    '{8'h07, 3'd0, 1'b0, 16'h2000, 2'd0, 2'd0}, // R10 two commands
    '{8'h05, 3'd0, 1'b1, 16'h2000, 2'd0, 2'd0}, // R4 load cannot claim store
    '{8'hE1, 3'd0, 1'b0, 16'h0002, 2'd1, 2'd0}, // R2 reserved ignored, fill
    '{8'h09, 3'd0, 1'b0, 16'h0001, 2'd0, 2'd0}  // R8 store cannot claim read
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(input logic ld);
    if (ld) ld_stb = 1'b1; else st_stb = 1'b1;
    @(negedge clk);
    st_stb = 1'b0; ld_stb = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000 && fl_busy; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", reg_rdata, 8'h00);
    chk("R1 busy", fl_busy, 0);
    chk("R1 start", fl_start, 0);
    chk("R1 cfg_valid", cfg_valid, 0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      string tag;
      zptr = VEC[v].z;
      write_reg(VEC[v].wd);
      repeat (VEC[v].gap) @(negedge clk);
      pulse(VEC[v].use_ld);
      tag = (VEC[v].kind == 2'd2) ? "R8" :
            (VEC[v].kind == 2'd0) ? "R4" :
            (VEC[v].op == 2'd0 || VEC[v].op == 2'd3) ? "R9" : "R5";
      chk({tag, " start"}, fl_start, (VEC[v].kind == 2'd1));
      chk({tag, " cfg_valid"}, cfg_valid, (VEC[v].kind == 2'd2));
      if (VEC[v].kind == 2'd1) begin
        chk({tag, " op"}, fl_op, VEC[v].op);
        chk({tag, " page"}, fl_page, VEC[v].z >> 5);
        if (VEC[v].op == 2'd0) chk({tag, " offs"}, fl_offs, (VEC[v].z >> 1) & 16'hF);
        chk({tag, " busy"}, fl_busy, (VEC[v].op == 2'd1 || VEC[v].op == 2'd2));
      end
      if (VEC[v].kind == 2'd2)
        chk({tag, " data"}, cfg_data, VEC[v].z[0] ? LOCK : FUSE);
      @(negedge clk);
      chk({tag, " no second pulse"}, fl_start | cfg_valid, 0);
      repeat (5) @(negedge clk);
      wait_idle();
      chk({tag, " rdata idle"}, reg_rdata, 8'h00);
    end

    // R3 readback and disarm
    write_reg(8'h05);
    chk("R3 readback", reg_rdata, 8'h05);
    write_reg(8'h00);
    chk("R3 disarm", reg_rdata, 8'h00);
    pulse(1'b0);
    chk("R3 no start after disarm", fl_start, 0);

    // R2 reserved bits
    write_reg(8'hE9);
    chk("R2 reserved read zero", reg_rdata, 8'h09);
    write_reg(8'h00);

    // R10 readback of illegal combination
    write_reg(8'h0F);
    chk("R10 readback", reg_rdata, 8'h00);

    // R6 busy length and read view, R7 writes ignored
    zptr = 16'h0420;
    write_reg(8'h05);
    pulse(1'b0);
    chk("R6 read while busy", reg_rdata, 8'h05);
    reg_wr = 1'b1; reg_wdata = 8'h03;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    chk("R7 write ignored", reg_rdata, 8'h05);
    n = 1;
    while (fl_busy && n < 1000) begin n++; @(negedge clk); end
    chk("R6 busy cycles", n, PROG);
    chk("R6 read after done", reg_rdata, 8'h00);
    pulse(1'b0);
    chk("R7 nothing armed", fl_start, 0);

    // R11 reset during erase
    write_reg(8'h03);
    pulse(1'b0);
    n = 0;
    repeat (10) begin n++; @(negedge clk); end
    rst = 1'b1;
    repeat (3) begin n++; @(negedge clk); end
    rst = 1'b0;
    chk("R11 busy after reset", fl_busy, 1);
    chk("R11 read after reset", reg_rdata, 8'h03);
    while (fl_busy && n < 1000) begin n++; @(negedge clk); end
    chk("R11 total busy cycles", n, PROG);

    // R12 strobe and register write on the same edge
    zptr = 16'h0860;
    write_reg(8'h05);
    st_stb = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h03;
    @(negedge clk);
    st_stb = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    chk("R12 start", fl_start, 1);
    chk("R12 op is claimed write", fl_op, 2);
    chk("R12 read shows claimed", reg_rdata, 8'h05);
    wait_idle();
    chk("R12 idle after", reg_rdata, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule